// File: doc/BRIEF.md
# Power-Down Wake-Up Controller

This block sequences the sleep and wake of a small microcontroller. Software writes 1 to a power-down bit; that write is the last thing the CPU does before its clock and the peripheral clocks are gated and the oscillator is switched off. The block then waits for a wake event. An event is a qualified low level on one of the external interrupt lines, or a qualified level on the keyboard line. A reset also ends the sleep.

Each kind of wake ends differently. An external-interrupt wake turns the oscillator on at once but keeps the clocks gated until every interrupt line that caused the wake has gone high again. A keyboard-only wake lets the oscillator settle for a fixed count of 1024 cycles and then restores the clocks, whatever level the key still has. In both cases the block gives a one-cycle wake-interrupt request when the clocks come back, together with a record of the sources that caused the wake. The block holds no register or RAM content of its own, so a wake by interrupt cannot disturb it.

Top module: `pwrdn_wake_ctl`

## Requirements
- R1: A write strobe with data 1 in phase ACTIVE gives, in the next cycle, phase SLEEP, pd_bit 1, osc_en 0 and both clock enables 0. A write with data 0 changes nothing.
- R2: The phase output is encoded as ACTIVE=0, SLEEP=1, SETTLE=2, HOLD=3.
- R3: External line i wakes the block only when ext_en[i] is 1, ext_lvl[i] is 1 (level-sensitive) and ext_n[i] is low. With any of these conditions unmet, the phase stays SLEEP.
- R4: In the cycle after a qualified wake, pd_bit is 0 and osc_en is 1, while both clock enables are still 0.
- R5: After an external wake the phase is HOLD and the clocks stay gated while any waking line is low. Phase ACTIVE with clocks enabled follows in the cycle after the last of these lines goes high.
- R6: After a keyboard-only wake the phase stays SETTLE for exactly 1024 cycles and then becomes ACTIVE, even if the key is still at its wake level.
- R7: With kbd_pol = 1 a high kbd_in wakes the block; with kbd_pol = 0 a low kbd_in wakes it; this needs kbd_en = 1.
- R8: When external and keyboard sources are qualified together, the external release rule applies (phase HOLD). wake_src records every qualified source: bit 2 is the keyboard, bits 1:0 are the external lines.
- R9: wake_irq is 1 for exactly the first ACTIVE cycle after a wake. wake_src keeps its value until the next entry into SLEEP.
- R10: An active-low asynchronous reset gives, at once, phase ACTIVE, pd_bit 0, osc_en 1, both clock enables 1, and wake_src 0. No settle count runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_wr | input | 1 | Write strobe for the power-down bit |
| pd_wdata | input | 1 | Value written to the power-down bit |
| ext_n | input | N_EXT | External interrupt lines, active low |
| ext_en | input | N_EXT | Enable for each external line |
| ext_lvl | input | N_EXT | 1 = line configured as level-sensitive |
| kbd_in | input | 1 | Keyboard wake line |
| kbd_en | input | 1 | Keyboard wake enable |
| kbd_pol | input | 1 | Keyboard trigger level: 1 high, 0 low |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wake_irq | output | 1 | One-cycle wake-interrupt request |
| wake_src | output | N_EXT+1 | Sources that caused the last wake |
| pd_bit | output | 1 | Readback of the power-down bit |
| phase | output | 2 | Current phase |

## Verification
The assertions assume that the enable, level-configuration and polarity inputs do not change while the block sleeps or wakes. They also assume that pd_wr is asserted only while the CPU clock runs. The stimulus sets these controls only in phase ACTIVE, before each sleep, and raises pd_wr only once the phase is back to ACTIVE. Every input is driven half a period away from the sampling edge, so the phase counts the assertions make on the settle window line up with the bench's own cycle counting.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_SLEEP  = 2'd1,
        PH_SETTLE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;
endpackage

// File: rtl/pdw_wake_qual.sv
module pdw_wake_qual #(
    parameter int N_EXT = 2
) (
    input  logic [N_EXT-1:0] ext_n,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_lvl,
    input  logic             kbd_in,
    input  logic             kbd_en,
    input  logic             kbd_pol,
    output logic [N_EXT-1:0] ext_hit,
    output logic             kbd_hit
);
    // Only level-sensitive, enabled lines that are low can wake.
    for (genvar g = 0; g < N_EXT; g++) begin : g_line
        assign ext_hit[g] = ext_en[g] & ext_lvl[g] & ~ext_n[g];
    end

    assign kbd_hit = kbd_en & (kbd_in == kbd_pol);
endmodule

// File: rtl/pdw_settle_cnt.sv
module pdw_settle_cnt #(
    parameter int SETTLE = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic done
);
    localparam int CW = (SETTLE > 2) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run && cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && !clr && (cnt_q == LAST);
endmodule

// File: rtl/pwrdn_wake_ctl.sv
module pwrdn_wake_ctl
    import pdw_pkg::*;
#(
    parameter int N_EXT  = 2,
    parameter int SETTLE = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_wr,
    input  logic             pd_wdata,
    input  logic [N_EXT-1:0] ext_n,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_lvl,
    input  logic             kbd_in,
    input  logic             kbd_en,
    input  logic             kbd_pol,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             wake_irq,
    output logic [N_EXT:0]   wake_src,
    output logic             pd_bit,
    output logic [1:0]       phase
);
    localparam int SW = N_EXT + 1;

    typedef struct packed {
        phase_e        ph;
        logic          pd;
        logic [SW-1:0] src;
        logic          irq;
    } ctl_s;

    ctl_s st_d, st_q;

    logic [N_EXT-1:0] ext_hit;
    logic             kbd_hit;
    logic             settle_done;

    pdw_wake_qual #(.N_EXT(N_EXT)) u_qual (
        .ext_n   (ext_n),
        .ext_en  (ext_en),
        .ext_lvl (ext_lvl),
        .kbd_in  (kbd_in),
        .kbd_en  (kbd_en),
        .kbd_pol (kbd_pol),
        .ext_hit (ext_hit),
        .kbd_hit (kbd_hit)
    );

    // Counter advances only while the oscillator runs.
    pdw_settle_cnt #(.SETTLE(SETTLE)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (osc_en),
        .clr   (st_q.ph != PH_SETTLE),
        .done  (settle_done)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        unique case (st_q.ph)
            PH_ACTIVE: begin
                if (pd_wr && pd_wdata) begin
                    st_d.ph  = PH_SLEEP;
                    st_d.pd  = 1'b1;
                    st_d.src = '0;
                end
            end
            PH_SLEEP: begin
                if (|ext_hit) begin
                    // External release rule wins over the keyboard count.
                    st_d.ph  = PH_HOLD;
                    st_d.pd  = 1'b0;
                    st_d.src = {kbd_hit, ext_hit};
                end else if (kbd_hit) begin
                    st_d.ph  = PH_SETTLE;
                    st_d.pd  = 1'b0;
                    st_d.src = {1'b1, {N_EXT{1'b0}}};
                end
            end
            PH_SETTLE: begin
                if (settle_done) begin
                    st_d.ph  = PH_ACTIVE;
                    st_d.irq = 1'b1;
                end
            end
            PH_HOLD: begin
                if ((st_q.src[N_EXT-1:0] & ~ext_n) == '0) begin
                    st_d.ph  = PH_ACTIVE;
                    st_d.irq = 1'b1;
                end
            end
            default: st_d.ph = PH_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_ACTIVE;
            st_q.pd  <= 1'b0;
            st_q.src <= '0;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign osc_en     = (st_q.ph != PH_SLEEP);
    assign cpu_clk_en = (st_q.ph == PH_ACTIVE);
    assign per_clk_en = (st_q.ph == PH_ACTIVE);
    assign wake_irq   = st_q.irq;
    assign wake_src   = st_q.src;
    assign pd_bit     = st_q.pd;
    assign phase      = st_q.ph;
endmodule

// File: rtl/pwrdn_wake_ctl_chk.sv
module pwrdn_wake_ctl_chk #(
    parameter int N_EXT  = 2,
    parameter int SETTLE = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pd_wr,
    input logic             pd_wdata,
    input logic [N_EXT-1:0] ext_n,
    input logic             osc_en,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             wake_irq,
    input logic [N_EXT:0]   wake_src,
    input logic             pd_bit,
    input logic [1:0]       phase
);
    int unsigned settle_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           settle_run <= 0;
        else if (phase == 2'd2) settle_run <= settle_run + 1;
        else                  settle_run <= 0;
    end

    // R1
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && pd_wr && pd_wdata) |=> (phase == 2'd1 && pd_bit && !osc_en));

    // R1
    sleep_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_bit |-> (!cpu_clk_en && !per_clk_en && !osc_en));

    // R4
    wake_osc_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && !pd_bit) |-> 1'b0);

    // R5
    hold_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3 && ((wake_src[N_EXT-1:0] & ~ext_n) != '0)) |=> !cpu_clk_en);

    // R6
    settle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && settle_run < SETTLE - 1) |=> phase == 2'd2);

    // R6
    settle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && settle_run == SETTLE - 1) |=> (phase == 2'd0 && cpu_clk_en));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);

    // R9
    irq_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (cpu_clk_en && per_clk_en && osc_en && !pd_bit));

    // R8
    src_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'd1 && $past(phase) != 2'd1 && $past(rst_n)) |-> $stable(wake_src));
endmodule

bind pwrdn_wake_ctl pwrdn_wake_ctl_chk #(.N_EXT(N_EXT), .SETTLE(SETTLE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_wr      (pd_wr),
    .pd_wdata   (pd_wdata),
    .ext_n      (ext_n),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .wake_irq   (wake_irq),
    .wake_src   (wake_src),
    .pd_bit     (pd_bit),
    .phase      (phase)
);

// File: tb/test_pwrdn_wake_ctl.sv
module test_pwrdn_wake_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_wr = 1'b0, pd_wdata = 1'b0;
    logic [1:0] ext_n = 2'b11, ext_en = 2'b11, ext_lvl = 2'b11;
    logic       kbd_in = 1'b0, kbd_en = 1'b1, kbd_pol = 1'b1;
    logic       osc_en, cpu_clk_en, per_clk_en, wake_irq, pd_bit;
    logic [2:0] wake_src;
    logic [1:0] phase;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwrdn_wake_ctl i_pwrdn_wake_ctl (
        .clk(clk), .rst_n(rst_n), .pd_wr(pd_wr), .pd_wdata(pd_wdata),
        .ext_n(ext_n), .ext_en(ext_en), .ext_lvl(ext_lvl),
        .kbd_in(kbd_in), .kbd_en(kbd_en), .kbd_pol(kbd_pol),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .wake_irq(wake_irq), .wake_src(wake_src), .pd_bit(pd_bit), .phase(phase)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            summary();
        end
    end

    task automatic go_sleep();
        @(negedge clk);
        pd_wr = 1'b1; pd_wdata = 1'b1;
        @(negedge clk);
        pd_wr = 1'b0; pd_wdata = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 phase", phase, 0);
        check("R10 pd_bit", pd_bit, 0);
        check("R10 osc_en", osc_en, 1);
        check("R10 cpu_clk_en", cpu_clk_en, 1);
        check("R10 wake_src", wake_src, 0);
    endtask

    task automatic t_write_zero();
        @(negedge clk);
        pd_wr = 1'b1; pd_wdata = 1'b0;
        @(negedge clk);
        pd_wr = 1'b0;
        check("R1 write0 phase", phase, 0);
        check("R1 write0 pd_bit", pd_bit, 0);
    endtask

    task automatic t_ext_wake();
        go_sleep();
        check("R1 sleep phase", phase, 1);
        check("R1 sleep pd_bit", pd_bit, 1);
        check("R1 sleep osc_en", osc_en, 0);
        check("R1 sleep clk_en", {cpu_clk_en, per_clk_en}, 0);
        ext_n = 2'b10;
        @(negedge clk);
        check("R4 pd_bit", pd_bit, 0);
        check("R4 osc_en", osc_en, 1);
        check("R2 R5 phase hold", phase, 3);
        repeat (40) @(negedge clk);
        check("R5 still hold", phase, 3);
        check("R5 clocks gated", cpu_clk_en, 0);
        ext_n = 2'b11;
        @(negedge clk);
        check("R5 released phase", phase, 0);
        check("R5 released clk", {cpu_clk_en, per_clk_en}, 3);
        check("R9 irq", wake_irq, 1);
        check("R8 src ext0", wake_src, 3'b001);
        @(negedge clk);
        check("R9 irq one cycle", wake_irq, 0);
        check("R9 src held", wake_src, 3'b001);
    endtask

    task automatic t_kbd(input logic pol);
        int n = 0;
        kbd_pol = pol;
        kbd_in = ~pol;
        go_sleep();
        check("R7 idle level keeps sleep", phase, 1);
        kbd_in = pol;
        @(negedge clk);
        check("R2 R6 settle phase", phase, 2);
        while (phase == 2 && n < 5000) begin
            n++;
            check("R6 clocks gated in settle", cpu_clk_en, 0);
            @(negedge clk);
        end
        check(pol ? "R6 R7 high count" : "R6 R7 low count", n, 1024);
        check("R6 active with key held", phase, 0);
        check("R9 kbd irq", wake_irq, 1);
        check("R8 src kbd", wake_src, 3'b100);
        kbd_in = ~pol;
        @(negedge clk);
    endtask

    task automatic t_ignored();
        ext_lvl = 2'b10;
        ext_en  = 2'b01;
        go_sleep();
        ext_n = 2'b00;
        repeat (20) @(negedge clk);
        check("R3 edge or disabled ignored", phase, 1);
        check("R3 osc stays off", osc_en, 0);
        ext_n = 2'b11;
        kbd_en = 1'b0; kbd_in = kbd_pol;
        repeat (5) @(negedge clk);
        check("R7 kbd disabled ignored", phase, 1);
        kbd_in = ~kbd_pol;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 async phase", phase, 0);
        check("R10 async pd_bit", pd_bit, 0);
        check("R10 async osc", osc_en, 1);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 no settle", phase, 0);
        ext_lvl = 2'b11; ext_en = 2'b11; kbd_en = 1'b1;
    endtask

    task automatic t_both();
        go_sleep();
        kbd_in = kbd_pol;
        ext_n = 2'b01;
        @(negedge clk);
        check("R8 ext rule wins", phase, 3);
        check("R8 src both", wake_src, 3'b110);
        repeat (3) @(negedge clk);
        ext_n = 2'b11;
        @(negedge clk);
        check("R8 release to active", phase, 0);
        kbd_in = ~kbd_pol;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_zero();
        t_ext_wake();
        t_kbd(1'b1);
        t_kbd(1'b0);
        t_ignored();
        t_both();
        done = 1'b1;
        summary();
    end
endmodule